// File: doc/BRIEF.md
# CPU Bus Region Decoder and Access Sequencer

This block sits between a processor core and the memory regions of a 24-bit bus. For each accepted request it latches the address and works out which region the address hits: work RAM, the B-side register window, the A-side internal register window, an external device, or nothing. From the bank and page it also works out how many master clocks the access takes. A fast-ROM control input shortens accesses in the upper half of the map. The block then holds the core with a ready signal for exactly that many clocks.

Reads sample the selected region's data a fixed four clocks before the end of the access. The sampled byte is returned with a one-cycle completion pulse. A byte-wide latch remembers the last value driven on the bus, and a read that hits no region returns that value instead of fresh data. Writes are strobed in the last clock of the access. A write to a page with no region still takes its full time but has no effect.

One clock cycle of `clk` equals one master clock. Register contents, the work RAM array and any external device decoding lie outside the block. Those parts see only the select lines, the latched address, the work RAM offset and the strobes.

Top module: `cpu_bus_sequencer`

## Requirements
- R1: Banks 7E and 7F select work RAM with `wram_addr` equal to address bits 16:0. In banks whose bit 6 is clear (00-3F, 80-BF), offsets 0000-1FFF also select work RAM, with `wram_addr` equal to address bits 12:0 zero-extended.
- R2: In banks 00-3F and 80-BF, offsets 2000-2FFF raise `sel_breg` and offsets 4000-4FFF raise `sel_areg`. At most one select line is ever high.
- R3: Any page not covered by R1 or R2 raises `sel_ext` when `ext_claim` was high with the request. Otherwise the page is unmapped and no select line rises.
- R4: Accesses to banks 40-7F last 8 clocks. Accesses to banks C0-FF last 6 clocks if `fast_rom_en` was high with the request, otherwise 8.
- R5: In banks 00-3F and 80-BF, offsets below 8000 take these times: 0000-1FFF 8 clocks, 2000-3FFF 6, 4000-41FF 12, 4200-5FFF 6, 6000-7FFF 8.
- R6: Offsets 8000-FFFF take 8 clocks in banks 00-3F. In banks 80-BF they take 6 clocks with `fast_rom_en` high, otherwise 8.
- R7: A request is accepted on a rising edge where `cpu_ready` is high. `cpu_ready` then stays low for exactly S cycles, where S is the access time. `acc_done` is high for exactly one cycle, the first cycle in which `cpu_ready` is high again. The select lines and `acc_addr` hold throughout the S cycles.
- R8: For a read, `sel_rdata` is sampled on the edge S-4 cycles after acceptance. `rd_stb` is high only in the cycle before that edge.
- R9: When `acc_done` is high after a read, `rd_data` holds either the byte sampled from a mapped region or, for an unmapped read, the open-bus latch. A mapped read loads the latch with its byte. The latch is 00 after reset.
- R10: For a write to a mapped region, `wr_stb` is high only in the last busy cycle, with `wr_data` equal to the request data. A write to an unmapped page raises no strobe, completes in its normal time and leaves the open-bus latch unchanged.
- R11: During and right after reset, `cpu_ready` is high and `acc_done`, `rd_stb`, `wr_stb`, all select lines and `rd_data` are low.
- R12: `req_valid` while `cpu_ready` is low is ignored: the current access's address, region and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bank (23:16) and offset (15:0) |
| req_wdata | input | 8 | Write byte |
| ext_claim | input | 1 | External device claims an otherwise unmapped page |
| fast_rom_en | input | 1 | Fast access for the upper half of the map |
| sel_rdata | input | 8 | Read data from the selected region |
| cpu_ready | output | 1 | Low while an access is in progress |
| acc_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result |
| rd_stb | output | 1 | Marks the cycle whose end samples `sel_rdata` |
| wr_stb | output | 1 | Write strobe to the selected region |
| wr_data | output | 8 | Latched write byte |
| acc_addr | output | 24 | Latched access address |
| wram_addr | output | 17 | Work RAM byte offset |
| sel_wram | output | 1 | Work RAM selected |
| sel_breg | output | 1 | B-side register window selected |
| sel_areg | output | 1 | A-side register window selected |
| sel_ext | output | 1 | External device selected |

## Verification
The assertions assume that the decoder only ever yields one of the three legal durations, each longer than the four-clock read tail. They also assume that a request arriving while busy is simply dropped. The stimulus drives inputs only on falling edges and holds `req_valid` for a single accepting edge. Extra requests are injected only in early busy cycles, so they always fall inside an access and never inside the completion cycle. The bench drives `sel_rdata` with a value that changes every busy cycle, which exposes any error in sampling time.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_WRAM = 3'd1,
    RGN_BREG = 3'd2,
    RGN_AREG = 3'd3,
    RGN_EXT  = 3'd4
  } region_e;
endpackage

// File: rtl/bus_map_decode.sv
module bus_map_decode
  import bus_dec_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int WRAM_AW = 17,
  parameter int MIRR_AW = 13
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ext_claim,
  output region_e            region,
  output logic [WRAM_AW-1:0] wram_addr
);
  localparam int BANK_LSB = ADDR_W - 8;

  logic [7:0] bank;
  logic [3:0] page4k;
  logic       sys_bank;
  logic       wram_bank;

  assign bank      = addr[ADDR_W-1:BANK_LSB];
  assign page4k    = addr[15:12];
  assign sys_bank  = ~bank[6];
  assign wram_bank = (bank[7:1] == 7'h3F);

  always_comb begin
    region    = RGN_NONE;
    wram_addr = '0;
    if (wram_bank) begin
      region    = RGN_WRAM;
      wram_addr = addr[WRAM_AW-1:0];
    end else if (sys_bank && page4k <= 4'h1) begin
      region    = RGN_WRAM;
      wram_addr = {{(WRAM_AW-MIRR_AW){1'b0}}, addr[MIRR_AW-1:0]};
    end else if (sys_bank && page4k == 4'h2) begin
      region = RGN_BREG;
    end else if (sys_bank && page4k == 4'h4) begin
      region = RGN_AREG;
    end else if (ext_claim) begin
      region = RGN_EXT;
    end
  end
endmodule

// File: rtl/bus_speed_decode.sv
module bus_speed_decode #(
  parameter int ADDR_W = 24,
  parameter int SLOW   = 8,
  parameter int FAST   = 6,
  parameter int XSLOW  = 12,
  parameter int CNT_W  = $clog2(XSLOW + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fast_rom,
  output logic [CNT_W-1:0]  speed
);
  localparam logic [CNT_W-1:0] C_SLOW  = CNT_W'(SLOW);
  localparam logic [CNT_W-1:0] C_FAST  = CNT_W'(FAST);
  localparam logic [CNT_W-1:0] C_XSLOW = CNT_W'(XSLOW);

  logic [7:0] bank;
  logic [7:0] page;
  logic       upper_fast;

  assign bank       = addr[ADDR_W-1:ADDR_W-8];
  assign page       = addr[15:8];
  assign upper_fast = bank[7] & fast_rom;

  always_comb begin
    if (bank[6] || page[7]) begin
      speed = upper_fast ? C_FAST : C_SLOW;
    end else if (page <= 8'h1F) begin
      speed = C_SLOW;
    end else if (page <= 8'h3F) begin
      speed = C_FAST;
    end else if (page <= 8'h41) begin
      speed = C_XSLOW;
    end else if (page <= 8'h5F) begin
      speed = C_FAST;
    end else begin
      speed = C_SLOW;
    end
  end
endmodule

// File: rtl/bus_access_seq.sv
module bus_access_seq
  import bus_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int WRAM_AW   = 17,
  parameter int SLOW      = 8,
  parameter int FAST      = 6,
  parameter int XSLOW     = 12,
  parameter int READ_TAIL = 4,
  parameter int CNT_W     = $clog2(XSLOW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [CNT_W-1:0]   speed,
  input  region_e            region,
  input  logic [WRAM_AW-1:0] wram_in,
  input  logic [DATA_W-1:0]  sel_rdata,
  output logic               ready,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_stb,
  output logic               wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic               sel_wram,
  output logic               sel_breg,
  output logic               sel_areg,
  output logic               sel_ext
);
  localparam logic [CNT_W-1:0] TAIL_CNT = CNT_W'(READ_TAIL);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               we_q;
  region_e            rgn_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WRAM_AW-1:0] wram_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  openbus_q;
  logic               done_q;
  logic               accept;
  logic               sample_now;

  assign accept     = req_valid & ~busy_q;
  assign sample_now = busy_q & ~we_q & (cnt_q == TAIL_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      we_q      <= 1'b0;
      rgn_q     <= RGN_NONE;
      addr_q    <= '0;
      wram_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      openbus_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cnt_q   <= speed - CNT_W'(1);
        we_q    <= req_we;
        rgn_q   <= region;
        addr_q  <= req_addr;
        wram_q  <= wram_in;
        wdata_q <= req_wdata;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rgn_q  <= RGN_NONE;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        if (sample_now) begin
          if (rgn_q == RGN_NONE) begin
            rdata_q <= openbus_q;
          end else begin
            rdata_q   <= sel_rdata;
            openbus_q <= sel_rdata;
          end
        end
      end
    end
  end

  assign ready     = ~busy_q;
  assign done      = done_q;
  assign rd_data   = rdata_q;
  assign rd_stb    = sample_now;
  assign wr_stb    = busy_q & we_q & (cnt_q == '0) & (rgn_q != RGN_NONE);
  assign wr_data   = wdata_q;
  assign acc_addr  = addr_q;
  assign wram_addr = wram_q;
  assign sel_wram  = (rgn_q == RGN_WRAM);
  assign sel_breg  = (rgn_q == RGN_BREG);
  assign sel_areg  = (rgn_q == RGN_AREG);
  assign sel_ext   = (rgn_q == RGN_EXT);

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_wram, sel_breg, sel_areg, sel_ext}));

  assert_speed_legal_R5: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((speed == CNT_W'(SLOW) || speed == CNT_W'(FAST) ||
                 speed == CNT_W'(XSLOW)) && speed > TAIL_CNT));

  assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0) |=> (done && ready));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_latch_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(openbus_q));

  assert_write_keeps_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && we_q) |=> $stable(openbus_q));

  assert_busy_req_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0 && req_valid) |=> ($stable(acc_addr) && !ready));
endmodule

// File: rtl/cpu_bus_sequencer.sv
module cpu_bus_sequencer
  import bus_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int WRAM_AW   = 17,
  parameter int MIRR_AW   = 13,
  parameter int SLOW      = 8,
  parameter int FAST      = 6,
  parameter int XSLOW     = 12,
  parameter int READ_TAIL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               ext_claim,
  input  logic               fast_rom_en,
  input  logic [DATA_W-1:0]  sel_rdata,
  output logic               cpu_ready,
  output logic               acc_done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_stb,
  output logic               wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic               sel_wram,
  output logic               sel_breg,
  output logic               sel_areg,
  output logic               sel_ext
);
  localparam int CNT_W = $clog2(XSLOW + 1);

  region_e            dec_region;
  logic [WRAM_AW-1:0] dec_wram;
  logic [CNT_W-1:0]   dec_speed;

  bus_map_decode #(
    .ADDR_W(ADDR_W), .WRAM_AW(WRAM_AW), .MIRR_AW(MIRR_AW)
  ) map_i (
    .addr(req_addr), .ext_claim(ext_claim),
    .region(dec_region), .wram_addr(dec_wram)
  );

  bus_speed_decode #(
    .ADDR_W(ADDR_W), .SLOW(SLOW), .FAST(FAST), .XSLOW(XSLOW), .CNT_W(CNT_W)
  ) speed_i (
    .addr(req_addr), .fast_rom(fast_rom_en), .speed(dec_speed)
  );

  bus_access_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRAM_AW(WRAM_AW), .SLOW(SLOW),
    .FAST(FAST), .XSLOW(XSLOW), .READ_TAIL(READ_TAIL), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .speed(dec_speed), .region(dec_region),
    .wram_in(dec_wram), .sel_rdata(sel_rdata),
    .ready(cpu_ready), .done(acc_done), .rd_data(rd_data),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .acc_addr(acc_addr), .wram_addr(wram_addr),
    .sel_wram(sel_wram), .sel_breg(sel_breg),
    .sel_areg(sel_areg), .sel_ext(sel_ext)
  );
endmodule

// File: tb/cpu_bus_sequencer_tb_top.sv
`timescale 1ns/1ps
module cpu_bus_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ext_claim = 1'b0;
  logic        fast_rom_en = 1'b0;
  logic [7:0]  sel_rdata = 8'hEE;
  logic        cpu_ready, acc_done, rd_stb, wr_stb;
  logic        sel_wram, sel_breg, sel_areg, sel_ext;
  logic [7:0]  rd_data, wr_data;
  logic [23:0] acc_addr;
  logic [16:0] wram_addr;

  always #2.5 clk = ~clk;

  cpu_bus_sequencer dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_claim(ext_claim),
    .fast_rom_en(fast_rom_en), .sel_rdata(sel_rdata),
    .cpu_ready(cpu_ready), .acc_done(acc_done), .rd_data(rd_data),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .acc_addr(acc_addr), .wram_addr(wram_addr), .sel_wram(sel_wram),
    .sel_breg(sel_breg), .sel_areg(sel_areg), .sel_ext(sel_ext)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // region codes: 0 none, 1 wram, 2 breg, 3 areg, 4 ext
  function automatic int exp_region(input logic [23:0] a, input bit ext);
    int b = int'(a[23:16]);
    int o = int'(a[15:0]);
    bit low = (b < 'h40) || (b >= 'h80 && b < 'hC0);
    if (b == 'h7E || b == 'h7F) return 1;
    if (low && o < 'h2000) return 1;
    if (low && o >= 'h2000 && o < 'h3000) return 2;
    if (low && o >= 'h4000 && o < 'h5000) return 3;
    return ext ? 4 : 0;
  endfunction

  function automatic int exp_wram(input logic [23:0] a);
    if (a[23:16] == 8'h7E || a[23:16] == 8'h7F) return int'(a[16:0]);
    return int'(a[12:0]);
  endfunction

  function automatic int exp_speed(input logic [23:0] a, input bit f);
    int b = int'(a[23:16]);
    int o = int'(a[15:0]);
    if (b >= 'h40 && b < 'h80) return 8;
    if (b >= 'hC0) return f ? 6 : 8;
    if (o >= 'h8000) return (b >= 'h80 && f) ? 6 : 8;
    if (o < 'h2000) return 8;
    if (o < 'h4000) return 6;
    if (o < 'h4200) return 12;
    if (o < 'h6000) return 6;
    return 8;
  endfunction

  function automatic string speed_tag(input logic [23:0] a);
    int b = int'(a[23:16]);
    if ((b >= 'h40 && b < 'h80) || b >= 'hC0) return "R4";
    if (a[15]) return "R6";
    return "R5";
  endfunction

  // behavioural reference model, advanced on each rising edge
  bit          m_busy = 0, m_done = 0, m_we = 0;
  int          m_k = 0, m_S = 0, m_rgn = 0, m_wram = 0;
  logic [23:0] m_addr = '0;
  logic [7:0]  m_base = '0, m_wd = '0, m_ob = '0, m_rdv = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_k = 0; m_ob = '0; m_rdv = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (!m_we && m_k == m_S - 5) begin
          if (m_rgn != 0) begin
            m_rdv = m_base ^ 8'(m_k);
            m_ob  = m_rdv;
          end else begin
            m_rdv = m_ob;
          end
        end
        if (m_k == m_S - 1) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_k++;
        end
      end else if (req_valid) begin
        m_busy = 1; m_k = 0; m_we = req_we; m_addr = req_addr; m_wd = req_wdata;
        m_S = exp_speed(req_addr, fast_rom_en);
        m_rgn = exp_region(req_addr, ext_claim);
        m_wram = exp_wram(req_addr);
        m_base = req_addr[7:0] ^ req_addr[15:8] ^ req_addr[23:16] ^ 8'h5A;
      end
    end
  end

  // region data changes every busy cycle, so a mistimed sample shows up
  always @(negedge clk) sel_rdata <= m_busy ? (m_base ^ 8'(m_k)) : 8'hEE;

  int low_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      string rt;
      rt = (m_rgn == 1) ? "R1" : (m_rgn == 4 || m_rgn == 0) ? "R3" : "R2";
      chk(cpu_ready == !m_busy, "R7", "cpu_ready", cpu_ready, !m_busy);
      chk(acc_done == m_done, "R7", "acc_done", acc_done, m_done);
      chk(sel_wram == (m_busy && m_rgn == 1), rt, "sel_wram", sel_wram, m_busy && m_rgn == 1);
      chk(sel_breg == (m_busy && m_rgn == 2), rt, "sel_breg", sel_breg, m_busy && m_rgn == 2);
      chk(sel_areg == (m_busy && m_rgn == 3), rt, "sel_areg", sel_areg, m_busy && m_rgn == 3);
      chk(sel_ext == (m_busy && m_rgn == 4), rt, "sel_ext", sel_ext, m_busy && m_rgn == 4);
      chk(rd_stb == (m_busy && !m_we && m_k == m_S - 5), "R8", "rd_stb", rd_stb,
          m_busy && !m_we && m_k == m_S - 5);
      chk(wr_stb == (m_busy && m_we && m_rgn != 0 && m_k == m_S - 1), "R10", "wr_stb",
          wr_stb, m_busy && m_we && m_rgn != 0 && m_k == m_S - 1);
      if (m_busy) begin
        chk(acc_addr == m_addr, "R12", "acc_addr", acc_addr, m_addr);
        if (m_rgn == 1) chk(int'(wram_addr) == m_wram, "R1", "wram_addr", wram_addr, m_wram);
        if (wr_stb) chk(wr_data == m_wd, "R10", "wr_data", wr_data, m_wd);
      end
      if (!cpu_ready) low_cnt++;
      if (m_done) begin
        chk(low_cnt == m_S, speed_tag(m_addr), "access length", low_cnt, m_S);
        if (!m_we) chk(rd_data == m_rdv, "R9", "rd_data", rd_data, m_rdv);
        low_cnt = 0;
      end
    end
  end

  task automatic access(input logic [23:0] a, input bit we, input logic [7:0] d,
                        input bit ext, input bit fast, input bit junk);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    ext_claim = ext; fast_rom_en = fast;
    @(negedge clk);
    req_valid = 0;
    if (junk) begin
      // R12: requests while busy must be dropped
      for (int i = 0; i < 2; i++) begin
        req_valid = 1; req_we = ~we; req_addr = a ^ 24'h3C5A5A;
        ext_claim = ~ext; fast_rom_en = ~fast;
        @(negedge clk);
      end
      req_valid = 0;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 100000);
      report();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11: reset state while reset is still asserted
    chk(cpu_ready == 1 && !acc_done && !rd_stb && !wr_stb, "R11", "ctrl in reset",
        {cpu_ready, acc_done, rd_stb, wr_stb}, 4'b1000);
    chk({sel_wram, sel_breg, sel_areg, sel_ext} == 0 && rd_data == 0, "R11",
        "selects/data in reset", {sel_wram, sel_breg, sel_areg, sel_ext, rd_data}, 0);
    rst = 0;
    @(negedge clk);
    chk(cpu_ready == 1 && rd_data == 0, "R11", "after reset", {cpu_ready, rd_data}, 9'h100);
    // R9: unmapped read right after reset returns a cleared latch
    access(24'h403000, 0, 8'h00, 0, 0, 0);
    access(24'h7E1234, 0, 8'h00, 0, 0, 0);   // R1, R4 wram high bank
    access(24'h7F8001, 1, 8'hA5, 0, 1, 1);   // R1, R12
    access(24'h000123, 0, 8'h00, 0, 0, 0);   // R1 mirror
    access(24'h801FFF, 1, 8'h3C, 0, 1, 0);   // R1 mirror upper
    access(24'h002140, 0, 8'h00, 0, 0, 1);   // R2 B window
    access(24'h003000, 0, 8'h00, 0, 0, 0);   // R3 unmapped, fast, R9 latch
    access(24'h004016, 0, 8'h00, 0, 0, 0);   // R2 A window, 12 clocks
    access(24'h8041FF, 1, 8'h77, 0, 1, 1);   // R5 12 clocks write
    access(24'h004200, 0, 8'h00, 0, 1, 0);   // R5 6 clocks
    access(24'h005000, 1, 8'h11, 0, 0, 0);   // R10 unmapped write
    access(24'h005000, 0, 8'h00, 0, 0, 0);   // R9 latch unchanged by write
    access(24'h006000, 0, 8'h00, 1, 0, 0);   // R3 external claim
    access(24'h008000, 0, 8'h00, 1, 1, 0);   // R6 slow in low bank
    access(24'h808000, 0, 8'h00, 1, 1, 0);   // R6 fast
    access(24'h808000, 1, 8'h22, 1, 0, 0);   // R6 slow
    access(24'hC00000, 0, 8'h00, 1, 1, 1);   // R4 fast
    access(24'hFF0000, 0, 8'h00, 0, 0, 0);   // R4 slow, R9 unmapped
    access(24'h400000, 0, 8'h00, 1, 1, 0);   // R4 banks 40-7F always slow
    access(24'h3F7FFF, 1, 8'h44, 0, 1, 0);   // R5 last slow page
    repeat (20) @(negedge clk);
    report();
  end
endmodule